// File: doc/BRIEF.md
# Four-Line Input Capture Timer

This block is a free-running up-counter (32 bits by default) with four capture lines. Each line watches either an external pin or a shared internal compare-match pulse. When a line sees a qualifying event, it copies the counter into its own register, sets a sticky status flag and pulses a DMA request for one cycle. The counter also produces a sticky wrap-around flag and three interval ticks. Each tick is taken from a counter bit position chosen at run time. Each tick either sets a CPU-visible flag or emits a one-cycle trigger toward an analog-to-digital converter.

Software-facing decoding lives elsewhere. This block takes configuration as plain input vectors and takes flag clears as write-one strobes. A single level interrupt line is the OR of every flag.

Top module: `cap_timer32`

## Requirements
- R1: `cnt_val` (CNT_W bits, default 32) rises by one at each clock edge where `cnt_en` is high, keeps its value otherwise, and wraps from all ones to zero.
- R2: A pin passes through two synchronizer flops before edge detection. For a pin change set up before clock edge e, the capture is visible after edge e+2 and holds the `cnt_val` seen between edges e+1 and e+2.
- R3: Line l takes its edge mode from `edge_sel[2l+1:2l]`: 00 means off, 01 means rising only, 10 means falling only, 11 means both edges. With mode 00 the line never captures.
- R4: On a capture, line l writes `cap_val[CNT_W*l +: CNT_W]`, sets `cap_flag[l]` and raises `dma_req[l]` for exactly the one cycle that follows the capturing edge.
- R5: With `trig_sel[l]` high, line l ignores its pin. At every edge where `cm_trig` is high and the line's mode is not 00, the line captures the `cnt_val` of that cycle.
- R6: An enabled increment from all ones sets `ovf_flag`.
- R7: Tick j selects counter bit `tick_bitsel[SEL_W*j +: SEL_W]`, where SEL_W = clog2(CNT_W). When an increment takes that bit from 0 to 1, the result depends on `tick_route[j]`. At 0 it sets `tick_flag[j]`. At 1 it raises `adc_trig[j]` for the next cycle only and leaves the flag alone. A selection at or above CNT_W never fires.
- R8: Every flag stays set until its strobe (`cap_clr`, `ovf_clr`, `tick_clr`) is high at a clock edge. When a set and a clear meet at the same edge, the flag ends up set.
- R9: `cpu_irq` is high exactly when any of `cap_flag`, `ovf_flag` or `tick_flag` is high.
- R10: Driving `rst_n` low clears every register at once. After `rst_n` rises, the first two clock edges still hold reset, and the third edge is the first functional one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter increment enable |
| cap_pin | input | LINES | External capture pins, asynchronous |
| cm_trig | input | 1 | Internal compare-match pulse |
| trig_sel | input | LINES | Per line: 1 uses `cm_trig` instead of the pin |
| edge_sel | input | 2*LINES | Per-line edge mode, two bits each |
| tick_bitsel | input | SEL_W*TICKS | Counter bit chosen for each interval tick |
| tick_route | input | TICKS | Per tick: 0 sets a CPU flag, 1 pulses `adc_trig` |
| cap_clr | input | LINES | Write-one clears for capture flags |
| ovf_clr | input | 1 | Write-one clear for the wrap flag |
| tick_clr | input | TICKS | Write-one clears for tick flags |
| cnt_val | output | CNT_W | Current counter value |
| cap_val | output | CNT_W*LINES | Captured values, line 0 in the low bits |
| cap_flag | output | LINES | Sticky capture flags |
| dma_req | output | LINES | One-cycle DMA request per capture |
| ovf_flag | output | 1 | Sticky counter wrap flag |
| tick_flag | output | TICKS | Sticky interval tick flags |
| adc_trig | output | TICKS | One-cycle conversion triggers |
| cpu_irq | output | 1 | OR of all flags |

## Verification
Faults in the synchronizer or the previous-sample register show up at the ports as a capture that lands one edge early or late. That in turn shows up as a `cap_val` off by the count of one cycle, within three edges of the pin change. A wrong edge-mode decode or a wrong trigger-source mux shows up as a flag set or missing on the first event of the affected kind. A wrong tick bit selection or a wrong previous-bit compare shows up when the selected bit next rises: at most 2^(bit+1) enabled cycles later, a flag or conversion pulse lands in the wrong place. The bench therefore compares every output against its model on every clock, so each of these divergences is reported in the cycle where it appears.

// File: rtl/cap_timer32_pkg.sv
package cap_timer32_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  // Qualifies a transition between the previous and current synchronized sample.
  function automatic logic edge_hit(input edge_mode_e mode, input logic cur, input logic prev);
    logic rise;
    logic fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    unique case (mode)
      EDGE_RISE: edge_hit = rise;
      EDGE_FALL: edge_hit = fall;
      EDGE_BOTH: edge_hit = rise | fall;
      default:   edge_hit = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ct_rst_sync.sv
module ct_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/ct_free_counter.sv
module ct_free_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             ovf_q
);
  logic wrap;
  logic ovf_d;

  always_comb begin
    cnt_nxt = en ? (cnt_q + CNT_W'(1)) : cnt_q;
    wrap    = en & (cnt_q == {CNT_W{1'b1}});
    ovf_d   = wrap | (ovf_q & ~ovf_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (en) begin
        cnt_q <= cnt_nxt;
      end
      ovf_q <= ovf_d;
    end
  end
endmodule

// File: rtl/ct_capture_line.sv
module ct_capture_line
  import cap_timer32_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin,
  input  logic             cm_trig,
  input  logic             use_cm,
  input  logic [1:0]       mode,
  input  logic             clr,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap_q,
  output logic             flag_q,
  output logic             dma_q
);
  // Stages 0..SYNC_STAGES-1 synchronize; the last stage keeps the previous sample.
  logic [SYNC_STAGES:0] shift_q;
  logic [SYNC_STAGES:0] shift_d;
  edge_mode_e           mode_e;
  logic                 pin_hit;
  logic                 hit;
  logic                 flag_d;

  always_comb begin
    mode_e  = edge_mode_e'(mode);
    shift_d = {shift_q[SYNC_STAGES-1:0], pin};
    pin_hit = edge_hit(mode_e, shift_q[SYNC_STAGES-1], shift_q[SYNC_STAGES]);
    if (use_cm) begin
      hit = cm_trig & (mode_e != EDGE_OFF);
    end else begin
      hit = pin_hit;
    end
    flag_d = hit | (flag_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      cap_q   <= '0;
      flag_q  <= 1'b0;
      dma_q   <= 1'b0;
    end else begin
      shift_q <= shift_d;
      if (hit) begin
        cap_q <= cnt;
      end
      flag_q <= flag_d;
      dma_q  <= hit;
    end
  end
endmodule

// File: rtl/ct_interval_tick.sv
module ct_interval_tick #(
  parameter int CNT_W = 32,
  parameter int SEL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [SEL_W-1:0] sel,
  input  logic             route_adc,
  input  logic             clr,
  output logic             flag_q,
  output logic             adc_q
);
  logic bit_now;
  logic bit_next;
  logic fire;
  logic flag_d;

  always_comb begin
    bit_now  = 1'b0;
    bit_next = 1'b0;
    for (int i = 0; i < CNT_W; i++) begin
      if (sel == SEL_W'(i)) begin
        bit_now  = cnt_q[i];
        bit_next = cnt_nxt[i];
      end
    end
    fire   = ~bit_now & bit_next;
    flag_d = (fire & ~route_adc) | (flag_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      adc_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      adc_q  <= fire & route_adc;
    end
  end
endmodule

// File: rtl/cap_timer32.sv
module cap_timer32 #(
  parameter int CNT_W       = 32,
  parameter int LINES       = 4,
  parameter int TICKS       = 3,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(CNT_W)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cnt_en,
  input  logic [LINES-1:0]       cap_pin,
  input  logic                   cm_trig,
  input  logic [LINES-1:0]       trig_sel,
  input  logic [2*LINES-1:0]     edge_sel,
  input  logic [SEL_W*TICKS-1:0] tick_bitsel,
  input  logic [TICKS-1:0]       tick_route,
  input  logic [LINES-1:0]       cap_clr,
  input  logic                   ovf_clr,
  input  logic [TICKS-1:0]       tick_clr,
  output logic [CNT_W-1:0]       cnt_val,
  output logic [CNT_W*LINES-1:0] cap_val,
  output logic [LINES-1:0]       cap_flag,
  output logic [LINES-1:0]       dma_req,
  output logic                   ovf_flag,
  output logic [TICKS-1:0]       tick_flag,
  output logic [TICKS-1:0]       adc_trig,
  output logic                   cpu_irq
);
  localparam int RST_STAGES = 2;

  logic             rst_i;
  logic [CNT_W-1:0] cnt_nxt;

  ct_rst_sync #(.STAGES(RST_STAGES)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_i)
  );

  ct_free_counter #(.CNT_W(CNT_W)) counter_i (
    .clk     (clk),
    .rst_n   (rst_i),
    .en      (cnt_en),
    .ovf_clr (ovf_clr),
    .cnt_q   (cnt_val),
    .cnt_nxt (cnt_nxt),
    .ovf_q   (ovf_flag)
  );

  for (genvar l = 0; l < LINES; l++) begin : g_line
    ct_capture_line #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) line_i (
      .clk     (clk),
      .rst_n   (rst_i),
      .pin     (cap_pin[l]),
      .cm_trig (cm_trig),
      .use_cm  (trig_sel[l]),
      .mode    (edge_sel[2*l +: 2]),
      .clr     (cap_clr[l]),
      .cnt     (cnt_val),
      .cap_q   (cap_val[CNT_W*l +: CNT_W]),
      .flag_q  (cap_flag[l]),
      .dma_q   (dma_req[l])
    );
  end

  for (genvar j = 0; j < TICKS; j++) begin : g_tick
    ct_interval_tick #(.CNT_W(CNT_W), .SEL_W(SEL_W)) tick_i (
      .clk       (clk),
      .rst_n     (rst_i),
      .cnt_q     (cnt_val),
      .cnt_nxt   (cnt_nxt),
      .sel       (tick_bitsel[SEL_W*j +: SEL_W]),
      .route_adc (tick_route[j]),
      .clr       (tick_clr[j]),
      .flag_q    (tick_flag[j]),
      .adc_q     (adc_trig[j])
    );
  end

  assign cpu_irq = (|cap_flag) | ovf_flag | (|tick_flag);
endmodule

// File: rtl/cap_timer32_chk.sv
module cap_timer32_chk #(
  parameter int CNT_W = 32,
  parameter int LINES = 4,
  parameter int TICKS = 3
) (
  input logic             clk,
  input logic             rst_i,
  input logic             cnt_en,
  input logic [CNT_W-1:0] cnt_val,
  input logic [LINES-1:0] cap_flag,
  input logic [LINES-1:0] cap_clr,
  input logic [LINES-1:0] dma_req,
  input logic             ovf_flag,
  input logic [TICKS-1:0] tick_route,
  input logic [TICKS-1:0] adc_trig
);
  // R1: enabled cycle advances by one
  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_i)
    cnt_en |=> (cnt_val == CNT_W'($past(cnt_val) + CNT_W'(1))));

  // R1: disabled cycle holds
  a_r1_count_hold: assert property (@(posedge clk) disable iff (!rst_i)
    !cnt_en |=> $stable(cnt_val));

  // R8: a set capture flag without a clear strobe survives the edge
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_i)
    (|(cap_flag & ~cap_clr)) |=> ((($past(cap_flag & ~cap_clr)) & ~cap_flag) == '0));

  // R4: a DMA request always comes with its capture flag
  a_r4_dma_with_flag: assert property (@(posedge clk) disable iff (!rst_i)
    (|dma_req) |-> ((dma_req & ~cap_flag) == '0));

  // R6: the wrap flag only rises after an enabled all-ones count
  a_r6_ovf_source: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(ovf_flag) |-> ($past(cnt_en) && ($past(cnt_val) == {CNT_W{1'b1}})));

  // R7: a conversion trigger only appears on a tick routed to the converter
  a_r7_adc_routed: assert property (@(posedge clk) disable iff (!rst_i)
    (|adc_trig) |-> (($past(tick_route) & adc_trig) == adc_trig));
endmodule

bind cap_timer32 cap_timer32_chk #(.CNT_W(CNT_W), .LINES(LINES), .TICKS(TICKS)) chk_i (.*);

// File: tb/cap_timer32_tb_top.sv
`timescale 1ns/1ps
module cap_timer32_tb_top;
  localparam int TW = 12;
  localparam int NL = 4;
  localparam int NT = 3;
  localparam int SW = $clog2(TW);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en = 1'b0;
  logic [NL-1:0] cap_pin = '0;
  logic cm_trig = 1'b0;
  logic [NL-1:0] trig_sel = '0;
  logic [2*NL-1:0] edge_sel = '0;
  logic [SW*NT-1:0] tick_bitsel = '0;
  logic [NT-1:0] tick_route = '0;
  logic [NL-1:0] cap_clr = '0;
  logic ovf_clr = 1'b0;
  logic [NT-1:0] tick_clr = '0;
  logic [TW-1:0] cnt_val;
  logic [TW*NL-1:0] cap_val;
  logic [NL-1:0] cap_flag, dma_req;
  logic ovf_flag, cpu_irq;
  logic [NT-1:0] tick_flag, adc_trig;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cap_timer32 #(.CNT_W(TW), .LINES(NL), .TICKS(NT), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cap_pin(cap_pin), .cm_trig(cm_trig),
    .trig_sel(trig_sel), .edge_sel(edge_sel), .tick_bitsel(tick_bitsel),
    .tick_route(tick_route), .cap_clr(cap_clr), .ovf_clr(ovf_clr), .tick_clr(tick_clr),
    .cnt_val(cnt_val), .cap_val(cap_val), .cap_flag(cap_flag), .dma_req(dma_req),
    .ovf_flag(ovf_flag), .tick_flag(tick_flag), .adc_trig(adc_trig), .cpu_irq(cpu_irq)
  );

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int unsigned m_cnt = 0;
  int unsigned m_cap[NL] = '{default: 0};
  bit m_cflag[NL] = '{default: 0};
  bit m_dma[NL] = '{default: 0};
  bit m_ovf = 0;
  bit m_tflag[NT] = '{default: 0};
  bit m_adc[NT] = '{default: 0};
  bit pin_hist[NL][$];
  int rel_edges = 0;
  localparam int unsigned MAXV = (1 << TW) - 1;

  task automatic model_reset();
    m_cnt = 0; m_ovf = 0;
    for (int l = 0; l < NL; l++) begin
      m_cap[l] = 0; m_cflag[l] = 0; m_dma[l] = 0;
      pin_hist[l] = '{0, 0, 0};
    end
    for (int j = 0; j < NT; j++) begin
      m_tflag[j] = 0; m_adc[j] = 0;
    end
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n || rel_edges < 2) begin
      if (!rst_n) rel_edges = 0; else rel_edges++;
      model_reset();
    end else begin
      int unsigned nxt;
      nxt = cnt_en ? ((m_cnt + 1) & MAXV) : m_cnt;
      for (int l = 0; l < NL; l++) begin
        int es;
        bit cur, prev, hit;
        es = int'(edge_sel[2*l +: 2]);
        cur = pin_hist[l][1];
        prev = pin_hist[l][2];
        if (trig_sel[l]) hit = cm_trig && (es != 0);
        else hit = (es == 1 && cur && !prev) || (es == 2 && !cur && prev) || (es == 3 && cur != prev);
        m_dma[l] = hit;
        if (hit) m_cap[l] = m_cnt;
        m_cflag[l] = hit || (m_cflag[l] && !cap_clr[l]);
        void'(pin_hist[l].pop_back());
        pin_hist[l].push_front(cap_pin[l]);
      end
      m_ovf = (cnt_en && m_cnt == MAXV) || (m_ovf && !ovf_clr);
      for (int j = 0; j < NT; j++) begin
        int sel;
        bit fire;
        sel = int'(tick_bitsel[SW*j +: SW]);
        fire = (sel < TW) && !m_cnt[sel] && nxt[sel];
        m_adc[j] = fire && tick_route[j];
        m_tflag[j] = (fire && !tick_route[j]) || (m_tflag[j] && !tick_clr[j]);
      end
      m_cnt = nxt;
    end
  end

  // Compare every output against the model on every clock
  always @(negedge clk) begin
    if (!done) begin
      bit any;
      any = m_ovf;
      check("R1", "cnt_val", 64'(cnt_val), 64'(m_cnt));
      for (int l = 0; l < NL; l++) begin
        check("R4", "cap_val", 64'(cap_val[TW*l +: TW]), 64'(m_cap[l]));
        check("R3 R8", "cap_flag", 64'(cap_flag[l]), 64'(m_cflag[l]));
        check("R4", "dma_req", 64'(dma_req[l]), 64'(m_dma[l]));
        any |= m_cflag[l];
      end
      check("R6", "ovf_flag", 64'(ovf_flag), 64'(m_ovf));
      for (int j = 0; j < NT; j++) begin
        check("R7", "tick_flag", 64'(tick_flag[j]), 64'(m_tflag[j]));
        check("R7", "adc_trig", 64'(adc_trig[j]), 64'(m_adc[j]));
        any |= m_tflag[j];
      end
      check("R9", "cpu_irq", 64'(cpu_irq), 64'(any));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    logic [TW-1:0] snap;
    lfsr = 16'hACE1;
    repeat (4) @(negedge clk);
    // R10: reset state
    check("R10", "cnt in reset", 64'(cnt_val), 64'd0);
    check("R10", "irq in reset", 64'(cpu_irq), 64'd0);
    rst_n = 1'b1;
    cnt_en = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R10", "cnt two edges after release", 64'(cnt_val), 64'd0);
    @(negedge clk);
    check("R10", "cnt three edges after release", 64'(cnt_val), 64'd1);

    // Mixed edge modes on pins, random clears (R3, R8)
    edge_sel = {2'b00, 2'b11, 2'b10, 2'b01};
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (i % 2 == 0) cap_pin = lfsr[3:0];
      cap_clr = lfsr[8] ? lfsr[7:4] : '0;
      cnt_en = lfsr[9] | lfsr[10];
      cm_trig = lfsr[11];
      @(negedge clk);
    end
    cap_clr = '1; cap_pin = '0; cm_trig = 1'b0; cnt_en = 1'b1;
    repeat (5) @(negedge clk);
    cap_clr = '0;
    @(negedge clk);

    // R2: latency of a pin rising edge on line 0
    cap_pin[0] = 1'b1;
    @(negedge clk);
    check("R2", "flag after one edge", 64'(cap_flag[0]), 64'd0);
    @(negedge clk);
    snap = cnt_val;
    check("R2", "flag after two edges", 64'(cap_flag[0]), 64'd0);
    @(negedge clk);
    check("R2", "flag after three edges", 64'(cap_flag[0]), 64'd1);
    check("R2", "captured value", 64'(cap_val[TW-1:0]), 64'(snap));
    check("R4", "dma pulse", 64'(dma_req[0]), 64'd1);
    @(negedge clk);
    check("R4", "dma one cycle", 64'(dma_req[0]), 64'd0);

    // R5: line 1 follows cm_trig, pin ignored
    trig_sel = 4'b0010;
    edge_sel[3:2] = 2'b01;
    cap_clr[1] = 1'b1;
    @(negedge clk);
    cap_clr[1] = 1'b0;
    for (int i = 0; i < 6; i++) begin
      cap_pin[1] = ~cap_pin[1];
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    check("R5", "pin ignored", 64'(cap_flag[1]), 64'd0);
    snap = cnt_val;
    cm_trig = 1'b1;
    @(negedge clk);
    cm_trig = 1'b0;
    check("R5", "cm capture value", 64'(cap_val[TW +: TW]), 64'(snap));
    check("R5", "cm capture flag", 64'(cap_flag[1]), 64'd1);
    // R3: mode off blocks the internal trigger too
    edge_sel[3:2] = 2'b00;
    cap_clr[1] = 1'b1;
    @(negedge clk);
    cap_clr[1] = 1'b0;
    cm_trig = 1'b1;
    @(negedge clk);
    cm_trig = 1'b0;
    @(negedge clk);
    check("R3", "off mode no capture", 64'(cap_flag[1]), 64'd0);

    // R6, R7, R8: ticks and wrap
    tick_bitsel = {4'd9, 4'd5, 4'd2};
    tick_route = 3'b010;
    cnt_en = 1'b1;
    while (cnt_val != TW'(MAXV - 1)) @(negedge clk);
    @(negedge clk);
    ovf_clr = 1'b1;
    @(negedge clk);
    check("R8", "set beats clear", 64'(ovf_flag), 64'd1);
    @(negedge clk);
    ovf_clr = 1'b0;
    check("R8", "clear strobe", 64'(ovf_flag), 64'd0);
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cnt_en = (i % 500) < 430;
      tick_clr = (i % 97 == 0) ? lfsr[2:0] : '0;
      if (i == 1500) begin
        tick_bitsel = {4'd14, 4'd3, 4'd0};
        tick_route = 3'b001;
      end
      @(negedge clk);
    end
    tick_clr = '0;
    check("R7", "out of range select quiet", 64'(tick_flag[2]), 64'(m_tflag[2]));
    finish_run();
  end
endmodule